// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative translation buffer with a parameterised number of entries. Each entry stores a virtual page-pair number, a per-entry page mask, an address-space identifier and a global bit. It also stores two independent page halves, even and odd. Each half holds its own frame number, 3-bit cache attribute, dirty bit and valid bit.

A lookup presents a virtual page-pair number and an identifier. The block answers within the same cycle from its registered table. It returns a hit flag, the index of the winning entry and a flag that reports more than one matching entry.

Software fills the table one entry at a time through an indexed write port. A single flush input clears the whole table. An indexed readback port returns an entry in a packed layout one cycle after the index is presented. Validity of a half is not part of the match; the translation stage that consumes the result checks it. Replacement choice, table walking and fault handling belong to neighbouring logic.

Top module: `pair_tlb`

## Requirements
- R1: An entry's page number matches the lookup page number when the two agree in every bit position where the entry's page mask bit is 0. Positions where the mask bit is 1 are ignored.
- R2: A hit additionally needs the entry's global bit to be 1, or its stored identifier to equal the lookup identifier.
- R3: When several entries match, `lk_index` gives the lowest-numbered one, and `lk_multi` is 1 exactly when two or more entries match.
- R4: When no entry matches, `lk_hit` is 0, `lk_index` is all ones and `lk_multi` is 0.
- R5: An indexed write with `wr_en` high updates the table at the next rising clock edge. A lookup in the same cycle as the write sees the old contents, and a lookup after that edge sees the new entry.
- R6: A write whose `wr_index` is equal to or greater than ENTRIES leaves every entry unchanged.
- R7: A `flush` cycle clears every field of every entry at the next edge, both valid bits included. Flush takes priority over a write in the same cycle.
- R8: An entry whose two valid bits are both 0 still takes part in matching. For example, after a clear, every entry matches page 0 with identifier 0.
- R9: Readback is registered, one cycle after `rd_index`. `rd_hi` equals the page number shifted left by 11, ORed with the identifier. `rd_lo0` and `rd_lo1` hold the half's frame number from bit 6 up, the cache attribute in bits 5:3, the dirty bit in bit 2, the valid bit in bit 1 and the global bit in bit 0. `rd_mask` is the page mask. An index of ENTRIES or more reads back all zeros.
- R10: A synchronous active-high `rst` clears the table in the same way as flush, and clears the readback outputs.
- R11: The even and odd halves of an entry are stored independently. Each readback half shows only the values written for that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Lookup page-pair number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_hit | output | 1 | At least one entry matches |
| lk_index | output | IDX_W | Lowest matching index, all ones on a miss |
| lk_multi | output | 1 | Two or more entries match |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | IDX_W+1 | Entry to write |
| wr_vpn | input | VPN_W | Page-pair number to store |
| wr_mask | input | VPN_W | Page mask to store |
| wr_asid | input | ASID_W | Identifier to store |
| wr_g | input | 1 | Global bit to store |
| wr_pfn0 | input | PFN_W | Even-half frame number |
| wr_c0 | input | 3 | Even-half cache attribute |
| wr_d0 | input | 1 | Even-half dirty bit |
| wr_v0 | input | 1 | Even-half valid bit |
| wr_pfn1 | input | PFN_W | Odd-half frame number |
| wr_c1 | input | 3 | Odd-half cache attribute |
| wr_d1 | input | 1 | Odd-half dirty bit |
| wr_v1 | input | 1 | Odd-half valid bit |
| flush | input | 1 | Clear the whole table |
| rd_index | input | IDX_W+1 | Entry to read back |
| rd_hi | output | VPN_W+11 | Packed page number and identifier |
| rd_mask | output | VPN_W | Stored page mask |
| rd_lo0 | output | PFN_W+6 | Packed even half with global bit |
| rd_lo1 | output | PFN_W+6 | Packed odd half with global bit |

## Verification
The bench builds the block with ENTRIES set to 6. A 3-bit lookup index then leaves the values 6 and 7 unused, which separates the all-ones miss index from every real entry. The 4-bit write and read index can also name the out-of-range entries 6, 7 and 13. The remaining parameters keep their default widths: a 19-bit page number, an 8-bit identifier and a 20-bit frame number. These widths allow a wide page mask to cover eight low bits while a neighbouring bit still decides a miss.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int TLB_ENTRIES_DEF = 8;
  localparam int TLB_VPN_W_DEF   = 19;
  localparam int TLB_ASID_W_DEF  = 8;
  localparam int TLB_PFN_W_DEF   = 20;
  localparam int CATTR_W         = 3;
  localparam int HI_SHIFT        = 11;
  // packed half layout, low to high: global, valid, dirty, attribute, frame
  localparam int LO_G_BIT   = 0;
  localparam int LO_V_BIT   = 1;
  localparam int LO_D_BIT   = 2;
  localparam int LO_C_LSB   = 3;
  localparam int LO_PFN_LSB = LO_C_LSB + CATTR_W;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int HALF_W  = 25,
  parameter int WIDX_W  = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               flush,
  input  logic                               wr_en,
  input  logic [WIDX_W-1:0]                  wr_index,
  input  logic [VPN_W-1:0]                   wr_vpn,
  input  logic [VPN_W-1:0]                   wr_mask,
  input  logic [ASID_W-1:0]                  wr_asid,
  input  logic                               wr_g,
  input  logic [HALF_W-1:0]                  wr_h0,
  input  logic [HALF_W-1:0]                  wr_h1,
  output logic [ENTRIES-1:0][VPN_W-1:0]      vpn_tab,
  output logic [ENTRIES-1:0][VPN_W-1:0]      mask_tab,
  output logic [ENTRIES-1:0][ASID_W-1:0]     asid_tab,
  output logic [ENTRIES-1:0]                 g_tab,
  output logic [ENTRIES-1:0][HALF_W-1:0]     h0_tab,
  output logic [ENTRIES-1:0][HALF_W-1:0]     h1_tab
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [VPN_W-1:0]  vpn_q;
    logic [VPN_W-1:0]  mask_q;
    logic [ASID_W-1:0] asid_q;
    logic              g_q;
    logic [HALF_W-1:0] h0_q;
    logic [HALF_W-1:0] h1_q;
    logic              sel;

    assign sel = wr_en && (wr_index == WIDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        vpn_q  <= '0;
        mask_q <= '0;
        asid_q <= '0;
        g_q    <= 1'b0;
        h0_q   <= '0;
        h1_q   <= '0;
      end else if (sel) begin
        vpn_q  <= wr_vpn;
        mask_q <= wr_mask;
        asid_q <= wr_asid;
        g_q    <= wr_g;
        h0_q   <= wr_h0;
        h1_q   <= wr_h1;
      end
    end

    assign vpn_tab[e]  = vpn_q;
    assign mask_tab[e] = mask_q;
    assign asid_tab[e] = asid_q;
    assign g_tab[e]    = g_q;
    assign h0_tab[e]   = h0_q;
    assign h1_tab[e]   = h1_q;
  end
endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell #(
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [VPN_W-1:0]  ent_mask,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_g,
  output logic              match
);
  logic [VPN_W-1:0] diff;
  logic             page_ok;
  logic             space_ok;

  assign diff     = (lk_vpn ^ ent_vpn) & ~ent_mask;
  assign page_ok  = (diff == '0);
  assign space_ok = ent_g || (ent_asid == lk_asid);
  assign match    = page_ok && space_ok;
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic               multi
);
  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    idx   = '1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i]) begin
        if (any) begin
          multi = 1'b1;
        end else begin
          any = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/tlb_readback.sv
module tlb_readback #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int HALF_W  = 25,
  parameter int WIDX_W  = 4,
  parameter int SHIFT   = 11
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [WIDX_W-1:0]              rd_index,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  mask_tab,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
  input  logic [ENTRIES-1:0]             g_tab,
  input  logic [ENTRIES-1:0][HALF_W-1:0] h0_tab,
  input  logic [ENTRIES-1:0][HALF_W-1:0] h1_tab,
  output logic [VPN_W+SHIFT-1:0]         rd_hi,
  output logic [VPN_W-1:0]               rd_mask,
  output logic [HALF_W:0]                rd_lo0,
  output logic [HALF_W:0]                rd_lo1
);
  localparam int HI_W = VPN_W + SHIFT;

  logic [HI_W-1:0]   hi_d;
  logic [VPN_W-1:0]  mask_d;
  logic [HALF_W:0]   lo0_d;
  logic [HALF_W:0]   lo1_d;

  always_comb begin
    hi_d   = '0;
    mask_d = '0;
    lo0_d  = '0;
    lo1_d  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_index == WIDX_W'(i)) begin
        hi_d   = (HI_W'(vpn_tab[i]) << SHIFT) | HI_W'(asid_tab[i]);
        mask_d = mask_tab[i];
        lo0_d  = {h0_tab[i], g_tab[i]};
        lo1_d  = {h1_tab[i], g_tab[i]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hi   <= '0;
      rd_mask <= '0;
      rd_lo0  <= '0;
      rd_lo1  <= '0;
    end else begin
      rd_hi   <= hi_d;
      rd_mask <= mask_d;
      rd_lo0  <= lo0_d;
      rd_lo1  <= lo1_d;
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES_DEF,
  parameter int VPN_W   = TLB_VPN_W_DEF,
  parameter int ASID_W  = TLB_ASID_W_DEF,
  parameter int PFN_W   = TLB_PFN_W_DEF,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WIDX_W = IDX_W + 1,
  localparam int HALF_W = PFN_W + CATTR_W + 2,
  localparam int LO_W   = HALF_W + 1,
  localparam int HI_W   = VPN_W + HI_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_index,
  output logic               lk_multi,
  input  logic               wr_en,
  input  logic [WIDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [VPN_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic               wr_g,
  input  logic [PFN_W-1:0]   wr_pfn0,
  input  logic [CATTR_W-1:0] wr_c0,
  input  logic               wr_d0,
  input  logic               wr_v0,
  input  logic [PFN_W-1:0]   wr_pfn1,
  input  logic [CATTR_W-1:0] wr_c1,
  input  logic               wr_d1,
  input  logic               wr_v1,
  input  logic               flush,
  input  logic [WIDX_W-1:0]  rd_index,
  output logic [HI_W-1:0]    rd_hi,
  output logic [VPN_W-1:0]   rd_mask,
  output logic [LO_W-1:0]    rd_lo0,
  output logic [LO_W-1:0]    rd_lo1
);
  logic [HALF_W-1:0]              wr_h0;
  logic [HALF_W-1:0]              wr_h1;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab;
  logic [ENTRIES-1:0][VPN_W-1:0]  mask_tab;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab;
  logic [ENTRIES-1:0]             g_tab;
  logic [ENTRIES-1:0][HALF_W-1:0] h0_tab;
  logic [ENTRIES-1:0][HALF_W-1:0] h1_tab;
  logic [ENTRIES-1:0]             hits;

  assign wr_h0 = {wr_pfn0, wr_c0, wr_d0, wr_v0};
  assign wr_h1 = {wr_pfn1, wr_c1, wr_d1, wr_v1};

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
    .HALF_W(HALF_W), .WIDX_W(WIDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_index(wr_index),
    .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_h0(wr_h0), .wr_h1(wr_h1),
    .vpn_tab(vpn_tab), .mask_tab(mask_tab), .asid_tab(asid_tab),
    .g_tab(g_tab), .h0_tab(h0_tab), .h1_tab(h1_tab)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    tlb_match_cell #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cell (
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .ent_vpn(vpn_tab[e]), .ent_mask(mask_tab[e]),
      .ent_asid(asid_tab[e]), .ent_g(g_tab[e]),
      .match(hits[e])
    );
  end

  tlb_prio_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hits(hits), .any(lk_hit), .idx(lk_index), .multi(lk_multi)
  );

  tlb_readback #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
    .HALF_W(HALF_W), .WIDX_W(WIDX_W), .SHIFT(HI_SHIFT)
  ) u_rb (
    .clk(clk), .rst(rst), .rd_index(rd_index),
    .vpn_tab(vpn_tab), .mask_tab(mask_tab), .asid_tab(asid_tab),
    .g_tab(g_tab), .h0_tab(h0_tab), .h1_tab(h1_tab),
    .rd_hi(rd_hi), .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1)
  );
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int IDX_W   = 3,
  parameter int HALF_W  = 25,
  parameter int HI_W    = 30
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           lk_hit,
  input logic [IDX_W-1:0]               lk_index,
  input logic                           lk_multi,
  input logic                           wr_en,
  input logic [IDX_W:0]                 wr_index,
  input logic [VPN_W-1:0]               wr_vpn,
  input logic [HALF_W-1:0]              wr_h0,
  input logic [HALF_W-1:0]              wr_h1,
  input logic                           flush,
  input logic [IDX_W:0]                 rd_index,
  input logic [HI_W-1:0]                rd_hi,
  input logic [VPN_W-1:0]               rd_mask,
  input logic [HALF_W:0]                rd_lo0,
  input logic [HALF_W:0]                rd_lo1,
  input logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
  input logic [ENTRIES-1:0]             g_tab,
  input logic [ENTRIES-1:0][HALF_W-1:0] h0_tab,
  input logic [ENTRIES-1:0][HALF_W-1:0] h1_tab
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(ENTRIES);

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit); // R3

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_index == '1) && !lk_multi); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && (wr_index < LIMIT)) |=>
      (vpn_tab[$past(wr_index[IDX_W-1:0])] == $past(wr_vpn)) &&
      (h0_tab[$past(wr_index[IDX_W-1:0])] == $past(wr_h0)) &&
      (h1_tab[$past(wr_index[IDX_W-1:0])] == $past(wr_h1))); // R5

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && (wr_index >= LIMIT)) |=>
      $stable(vpn_tab) && $stable(g_tab) && $stable(h0_tab) && $stable(h1_tab)); // R6

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vpn_tab == '0) && (g_tab == '0) && (h0_tab == '0) && (h1_tab == '0)); // R7

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_index >= LIMIT) |=>
      (rd_hi == '0) && (rd_mask == '0) && (rd_lo0 == '0) && (rd_lo1 == '0)); // R9
endmodule

bind pair_tlb pair_tlb_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W),
  .HALF_W(HALF_W), .HI_W(HI_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_hit(lk_hit), .lk_index(lk_index), .lk_multi(lk_multi),
  .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_h0(wr_h0), .wr_h1(wr_h1),
  .flush(flush), .rd_index(rd_index), .rd_hi(rd_hi), .rd_mask(rd_mask),
  .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
  .vpn_tab(vpn_tab), .g_tab(g_tab), .h0_tab(h0_tab), .h1_tab(h1_tab)
);

// File: tb/tb_pair_tlb.sv
module tb_pair_tlb;
  localparam int ENTRIES = 6;
  localparam int VPN_W   = 19;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = 20;
  localparam int IDX_W   = 3;
  localparam int HI_W    = VPN_W + 11;
  localparam int LO_W    = PFN_W + 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [VPN_W-1:0]  lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_index;
  logic              lk_multi;
  logic              wr_en = 1'b0;
  logic [IDX_W:0]    wr_index = '0;
  logic [VPN_W-1:0]  wr_vpn = '0;
  logic [VPN_W-1:0]  wr_mask = '0;
  logic [ASID_W-1:0] wr_asid = '0;
  logic              wr_g = 1'b0;
  logic [PFN_W-1:0]  wr_pfn0 = '0;
  logic [2:0]        wr_c0 = '0;
  logic              wr_d0 = 1'b0;
  logic              wr_v0 = 1'b0;
  logic [PFN_W-1:0]  wr_pfn1 = '0;
  logic [2:0]        wr_c1 = '0;
  logic              wr_d1 = 1'b0;
  logic              wr_v1 = 1'b0;
  logic              flush = 1'b0;
  logic [IDX_W:0]    rd_index = '0;
  logic [HI_W-1:0]   rd_hi;
  logic [VPN_W-1:0]  rd_mask;
  logic [LO_W-1:0]   rd_lo0;
  logic [LO_W-1:0]   rd_lo1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pair_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) dut (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_index(lk_index), .lk_multi(lk_multi),
    .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_c0(wr_c0), .wr_d0(wr_d0), .wr_v0(wr_v0),
    .wr_pfn1(wr_pfn1), .wr_c1(wr_c1), .wr_d1(wr_d1), .wr_v1(wr_v1),
    .flush(flush), .rd_index(rd_index),
    .rd_hi(rd_hi), .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1)
  );

  function automatic logic [LO_W-1:0] lo_of(input logic [PFN_W-1:0] pfn, input logic [2:0] c,
                                            input logic d, input logic v, input logic g);
    return (LO_W'(pfn) << 6) | (LO_W'(c) << 3) | (LO_W'(d) << 2) | (LO_W'(v) << 1) | LO_W'(g);
  endfunction

  function automatic logic [HI_W-1:0] hi_of(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid);
    return (HI_W'(vpn) << 11) | HI_W'(asid);
  endfunction

  task automatic expect_lk(input string req, input logic eh, input logic [IDX_W-1:0] ei, input logic em);
    checks++;
    if (lk_hit !== eh || lk_index !== ei || lk_multi !== em) begin
      errors++;
      $display("FAIL %s: lookup hit/idx/multi = %0b/%0d/%0b, expected %0b/%0d/%0b",
               req, lk_hit, lk_index, lk_multi, eh, ei, em);
    end
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic eh, input logic [IDX_W-1:0] ei, input logic em);
    @(negedge clk);
    lk_vpn = v; lk_asid = a;
    #1;
    expect_lk(req, eh, ei, em);
  endtask

  task automatic rd_chk(input string req, input logic [IDX_W:0] idx, input logic [HI_W-1:0] ehi,
                        input logic [VPN_W-1:0] emask, input logic [LO_W-1:0] e0, input logic [LO_W-1:0] e1);
    @(negedge clk);
    rd_index = idx;
    @(posedge clk);
    #1;
    checks++;
    if (rd_hi !== ehi || rd_mask !== emask || rd_lo0 !== e0 || rd_lo1 !== e1) begin
      errors++;
      $display("FAIL %s: read %0d hi/mask/lo0/lo1 = %h/%h/%h/%h, expected %h/%h/%h/%h",
               req, idx, rd_hi, rd_mask, rd_lo0, rd_lo1, ehi, emask, e0, e1);
    end
  endtask

  task automatic set_wr(input logic [IDX_W:0] idx, input logic [VPN_W-1:0] v, input logic [VPN_W-1:0] m,
                        input logic [ASID_W-1:0] a, input logic g,
                        input logic [PFN_W-1:0] p0, input logic [2:0] c0, input logic d0, input logic v0,
                        input logic [PFN_W-1:0] p1, input logic [2:0] c1, input logic d1, input logic v1);
    wr_en = 1'b1; wr_index = idx; wr_vpn = v; wr_mask = m; wr_asid = a; wr_g = g;
    wr_pfn0 = p0; wr_c0 = c0; wr_d0 = d0; wr_v0 = v0;
    wr_pfn1 = p1; wr_c1 = c1; wr_d1 = d1; wr_v1 = v1;
  endtask

  task automatic wr(input logic [IDX_W:0] idx, input logic [VPN_W-1:0] v, input logic [VPN_W-1:0] m,
                    input logic [ASID_W-1:0] a, input logic g);
    @(negedge clk);
    set_wr(idx, v, m, a, g, 20'h0, 3'd0, 1'b0, 1'b0, 20'h0, 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    // R10 R8: cleared table, all entries match page 0 / id 0
    rd_chk("R10", 4'd0, '0, '0, '0, '0);
    rd_chk("R10", 4'd5, '0, '0, '0, '0);
    look("R8", 19'h0, 8'h0, 1'b1, 3'd0, 1'b1);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    set_wr(4'd2, 19'h12340, 19'h0, 8'h05, 1'b0,
           20'hABCDE, 3'd3, 1'b1, 1'b1, 20'h13579, 3'd5, 1'b0, 1'b0);
    lk_vpn = 19'h12340; lk_asid = 8'h05;
    #1;
    expect_lk("R5 same-cycle old", 1'b0, 3'b111, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    expect_lk("R5 after edge", 1'b1, 3'd2, 1'b0);
    // R9 R11: packed readback, independent halves
    rd_chk("R9 R11", 4'd2, hi_of(19'h12340, 8'h05), 19'h0,
           lo_of(20'hABCDE, 3'd3, 1'b1, 1'b1, 1'b0), lo_of(20'h13579, 3'd5, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_asid_global;
    look("R2 id mismatch", 19'h12340, 8'h06, 1'b0, 3'b111, 1'b0);
    look("R4 miss", 19'h0ABCD, 8'h05, 1'b0, 3'b111, 1'b0);
    wr(4'd4, 19'h20000, 19'h000FF, 8'h09, 1'b1);
    look("R1 R2 masked global", 19'h200A5, 8'd77, 1'b1, 3'd4, 1'b0);
    look("R1 bit outside mask", 19'h20100, 8'h09, 1'b0, 3'b111, 1'b0);
  endtask

  task automatic t_multi;
    wr(4'd5, 19'h200A5, 19'h0, 8'h00, 1'b1);
    look("R3 two hits", 19'h200A5, 8'h01, 1'b1, 3'd4, 1'b1);
    wr(4'd1, 19'h200A0, 19'h0000F, 8'h00, 1'b1);
    look("R3 lowest wins", 19'h200A5, 8'h01, 1'b1, 3'd1, 1'b1);
    look("R3 single hit", 19'h20010, 8'h01, 1'b1, 3'd4, 1'b0);
  endtask

  task automatic t_out_of_range;
    wr(4'd6, 19'h7FFFF, 19'h0, 8'h03, 1'b1);
    wr(4'd13, 19'h7FFFF, 19'h0, 8'h03, 1'b1);
    look("R6 no new entry", 19'h7FFFF, 8'h03, 1'b0, 3'b111, 1'b0);
    rd_chk("R6 entry 2 kept", 4'd2, hi_of(19'h12340, 8'h05), 19'h0,
           lo_of(20'hABCDE, 3'd3, 1'b1, 1'b1, 1'b0), lo_of(20'h13579, 3'd5, 1'b0, 1'b0, 1'b0));
    rd_chk("R9 out-of-range read", 4'd6, '0, '0, '0, '0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    set_wr(4'd3, 19'h33333, 19'h0, 8'h07, 1'b1,
           20'h11111, 3'd1, 1'b1, 1'b1, 20'h22222, 3'd2, 1'b1, 1'b1);
    flush = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; flush = 1'b0;
    rd_chk("R7 entry 3", 4'd3, '0, '0, '0, '0);
    rd_chk("R7 entry 4", 4'd4, '0, '0, '0, '0);
    look("R7 old gone", 19'h200A5, 8'h01, 1'b0, 3'b111, 1'b0);
    look("R8 after flush", 19'h0, 8'h0, 1'b1, 3'd0, 1'b1);
  endtask

  task automatic t_mid_reset;
    wr(4'd0, 19'h00055, 19'h0, 8'h02, 1'b0);
    look("R5 entry 0", 19'h00055, 8'h02, 1'b1, 3'd0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    look("R10 cleared", 19'h00055, 8'h02, 1'b0, 3'b111, 1'b0);
    rd_chk("R10 read", 4'd0, '0, '0, '0, '0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_write_timing();
    t_asid_global();
    t_multi();
    t_out_of_range();
    t_flush();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule